// File: doc/BRIEF.md
# Presettable Decade/Binary Up-Down Counter

This block is a 4-bit synchronous up/down counter. A build-time parameter sets its modulus: ten (decade, BCD codes 0 to 9) or sixteen (full binary). Each rising clock edge moves the count one step in the direction picked by `up`. An active-low count enable, `cin_n`, can stop the count. An active-high clear and an active-high parallel load override the clock.

The terminal-count output `cout_n` is active low and responds combinationally to `cin_n`. Several stages can therefore share one clock and form a wider counter: the `cout_n` of a lower stage drives the `cin_n` of the next higher stage.

In decade mode the six codes above nine can only be reached through the load. The next-state map sends each of them back into the legal range within a few clocks.

Top module: `updn_ctr`

## Requirements
- R1: While `rst` is high the count is 0 and stays 0 on clock edges, whatever the values of `load`, `cin_n`, `up` and `jam`. The clear acts without waiting for a clock edge.
- R2: With `rst` low, a rising edge on `load` places `jam` into the count at once, and every clock edge while `load` is high loads `jam` again. `jam` must stay stable while `load` is high.
- R3: With `rst`, `load` and `cin_n` all low, each rising clock edge adds one to the count when `up` is 1 and subtracts one when `up` is 0.
- R4: With `cin_n` high, the count keeps its value on clock edges.
- R5: Counting up wraps from 9 to 0 in decade mode and from 15 to 0 in binary mode. Counting down wraps from 0 to 9 in decade mode and from 0 to 15 in binary mode.
- R6: `cout_n` is 0 exactly when `cin_n` is 0 and the count is at its terminal value; at all other times it is 1. The terminal value is 0 when `up` is 0. When `up` is 1 it is 9 in decade mode and 15 in binary mode.
- R7: In decade mode, counting up from an illegal code works as follows. Codes 10, 12 and 14 step to the next code. Codes 11, 13 and 15 step to 0. A legal code is therefore reached within two counting clocks.
- R8: In decade mode, counting down from any code between 10 and 15 steps to that code minus 8, which is a legal code between 2 and 7. A legal code is reached within four counting clocks.
- R9: After `rst` and `load` are released, the count takes its next step on the first rising clock edge.
- R10: Three binary stages share one clock, with each `cout_n` driving the next stage's `cin_n`. Together they count through 12 bits as a single modulo-4096 up/down counter, and the top stage's `cout_n` is 0 only at the chain's terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Active-high clear, highest priority |
| load | input | 1 | Active-high parallel load of `jam` |
| jam | input | 4 | Value to load |
| cin_n | input | 1 | Active-low count enable / chain carry in |
| up | input | 1 | 1 counts up, 0 counts down |
| cnt | output | 4 | Current count |
| cout_n | output | 1 | Active-low terminal-count carry out |

## Verification
A decade instance and a binary instance receive the same stimulus. Every one of the 16 load values is tried in each direction, followed by twenty counting clocks with a hold clock inserted now and then. The two moduli react differently to the same codes, so this sweep separates the decade wrap and the illegal-code map from plain binary counting. It also separates hold from step, and checks `cout_n` both before and after each edge.

Reset is applied with load and enable active, which shows the priority order. A 12-bit chain is loaded just below its top value, counted up through the wrap and then down through zero. These runs show that the carry ripples correctly across stage boundaries.

// File: rtl/updn_pkg.sv
package updn_pkg;
    localparam int CNT_W   = 4;
    localparam int DEC_TOP = 9;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;
endpackage

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t cur,
    input  logic up,
    output cnt_t nxt
);
    localparam cnt_t TOP = DECADE ? cnt_t'(DEC_TOP) : {CNT_W{1'b1}};

    cnt_t inc;
    cnt_t dec;

    generate
        if (DECADE) begin : g_dec
            always_comb begin
                if (cur > TOP) begin
                    // odd illegal codes return to zero, even ones step once
                    inc = cur[0] ? '0 : cur + cnt_t'(1);
                    dec = cur - cnt_t'(8);
                end else begin
                    inc = (cur == TOP) ? '0 : cur + cnt_t'(1);
                    dec = (cur == '0) ? TOP : cur - cnt_t'(1);
                end
            end
        end else begin : g_bin
            always_comb begin
                inc = cur + cnt_t'(1);
                dec = cur - cnt_t'(1);
            end
        end
    endgenerate

    assign nxt = up ? inc : dec;
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t cur,
    input  logic up,
    input  logic cin_n,
    output logic cout_n
);
    localparam cnt_t TOP = DECADE ? cnt_t'(DEC_TOP) : {CNT_W{1'b1}};

    logic at_term;

    always_comb begin
        at_term = up ? (cur == TOP) : (cur == '0);
        cout_n  = ~(~cin_n & at_term);
    end
endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] jam,
    input  logic       cin_n,
    input  logic       up,
    output logic [3:0] cnt,
    output logic       cout_n
);
    localparam cnt_t TOP = DECADE ? cnt_t'(DEC_TOP) : {CNT_W{1'b1}};

    ctr_state_t st_d;
    ctr_state_t st_q;
    cnt_t       step_nxt;

    updn_next #(.DECADE(DECADE)) u_next (
        .cur (st_q.cnt),
        .up  (up),
        .nxt (step_nxt)
    );

    updn_term #(.DECADE(DECADE)) u_term (
        .cur    (st_q.cnt),
        .up     (up),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    always_comb begin
        st_d = st_q;
        if (!cin_n) begin
            st_d.cnt = step_nxt;
        end
    end

    always_ff @(posedge clk or posedge rst or posedge load) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q.cnt <= jam;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R1: clear dominates every other input
    always @(negedge clk) begin
        if (rst) begin
            p_reset_clear_r1: assert (cnt == 4'd0);
        end
    end

    // R6: carry out only asserted with enable low and at a terminal code
    always @(negedge clk) begin
        if (!rst && !cout_n) begin
            p_carry_gate_r6: assert (!cin_n && (up ? (cnt == TOP) : (cnt == 4'd0)));
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst || load)
        cin_n |=> cnt == $past(cnt));

    p_up_step_r3: assert property (@(posedge clk) disable iff (rst || load)
        (!cin_n && up && cnt < TOP) |=> cnt == $past(cnt) + 4'd1);

    p_dn_step_r3: assert property (@(posedge clk) disable iff (rst || load)
        (!cin_n && !up && cnt != 4'd0 && cnt <= TOP) |=> cnt == $past(cnt) - 4'd1);

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst || load)
        (!cin_n && up && cnt == TOP) |=> cnt == 4'd0);

    generate
        if (DECADE) begin : g_chk
            p_illegal_up_r7: assert property (@(posedge clk) disable iff (rst || load)
                (!cin_n && up && cnt > TOP) |=> (cnt <= TOP || cnt[0]));
            p_illegal_dn_r8: assert property (@(posedge clk) disable iff (rst || load)
                (!cin_n && !up && cnt > TOP) |=> cnt <= TOP);
        end
    endgenerate
endmodule

// File: tb/updn_ctr_tb.sv
module updn_ctr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [3:0] jam = 4'd0;
    logic       cin_n = 1'b0;
    logic       up = 1'b1;
    logic [3:0] cnt;
    logic       cout_n;
    logic [3:0] cnt_b;
    logic       cout_b_n;
    logic [3:0] c0, c1, c2;
    logic       co0_n, co1_n, co2_n;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    updn_ctr #(.DECADE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .load(load), .jam(jam), .cin_n(cin_n), .up(up),
        .cnt(cnt), .cout_n(cout_n)
    );
    updn_ctr #(.DECADE(1'b0)) u_bin (
        .clk(clk), .rst(rst), .load(load), .jam(jam), .cin_n(cin_n), .up(up),
        .cnt(cnt_b), .cout_n(cout_b_n)
    );
    updn_ctr #(.DECADE(1'b0)) u_c0 (
        .clk(clk), .rst(rst), .load(load), .jam(jam), .cin_n(cin_n), .up(up),
        .cnt(c0), .cout_n(co0_n)
    );
    updn_ctr #(.DECADE(1'b0)) u_c1 (
        .clk(clk), .rst(rst), .load(load), .jam(jam), .cin_n(co0_n), .up(up),
        .cnt(c1), .cout_n(co1_n)
    );
    updn_ctr #(.DECADE(1'b0)) u_c2 (
        .clk(clk), .rst(rst), .load(load), .jam(jam), .cin_n(co1_n), .up(up),
        .cnt(c2), .cout_n(co2_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int ref_next(input bit dec, input bit u, input int v);
        if (!dec) return u ? (v + 1) % 16 : (v + 15) % 16;
        if (u) begin
            if (v < 9) return v + 1;
            if (v == 9) return 0;
            return (v % 2 == 0) ? v + 1 : 0;
        end
        if (v >= 10) return v - 8;
        return (v == 0) ? 9 : v - 1;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        int md, mb, steps, mc;
        bit ill, c;
        string tag;

        @(negedge clk);
        chk("R1 reset state", cnt, 0);
        chk("R6 carry at reset count 0 up", cout_n, 1);
        rst = 1'b0;
        jam = 4'd5;
        load = 1'b1;
        cin_n = 1'b0;
        #1;
        chk("R2 async load", cnt, 5);
        rst = 1'b1;
        #1;
        chk("R1 async clear over load", cnt, 0);
        tick();
        chk("R1 clear holds on edge", cnt, 0);
        rst = 1'b0;
        load = 1'b0;
        up = 1'b1;
        tick();
        chk("R9 resume after release", cnt, 1);

        for (int j = 0; j < 16; j++) begin
            for (int u = 0; u < 2; u++) begin
                jam = 4'(j);
                load = 1'b1;
                up = u[0];
                cin_n = 1'b0;
                tick();
                chk("R2 load decade", cnt, j);
                chk("R2 load binary", cnt_b, j);
                load = 1'b0;
                md = j;
                mb = j;
                ill = (j >= 10);
                steps = 0;
                for (int k = 0; k < 20; k++) begin
                    c = (k % 7 == 5);
                    cin_n = c;
                    #1;
                    chk("R6 carry decade", cout_n, (!c && md == (u ? 9 : 0)) ? 0 : 1);
                    chk("R6 carry binary", cout_b_n, (!c && mb == (u ? 15 : 0)) ? 0 : 1);
                    if (c) tag = "R4 hold";
                    else if (k == 0) tag = "R9 first step";
                    else if (md >= 10) tag = u ? "R7 illegal up" : "R8 illegal down";
                    else if (md == (u ? 9 : 0)) tag = "R5 wrap decade";
                    else tag = "R3 step";
                    if (!c) begin
                        md = ref_next(1'b1, u[0], md);
                        mb = ref_next(1'b0, u[0], mb);
                        if (ill) steps++;
                    end
                    tick();
                    chk(tag, cnt, md);
                    chk((!c && mb == (u ? 0 : 15)) ? "R5 wrap binary" : "R3 binary", cnt_b, mb);
                    if (ill && md <= 9) begin
                        chk(u ? "R7 recovery bound" : "R8 recovery bound",
                            (steps <= (u ? 2 : 4)) ? 1 : 0, 1);
                        ill = 1'b0;
                    end
                end
            end
        end

        jam = 4'hE;
        load = 1'b1;
        cin_n = 1'b0;
        up = 1'b1;
        tick();
        load = 1'b0;
        mc = 12'hEEE;
        chk("R10 chain load", {c2, c1, c0}, mc);
        for (int k = 0; k < 700; k++) begin
            up = (k < 300);
            #1;
            chk("R10 chain carry", co2_n, (mc == (up ? 4095 : 0)) ? 0 : 1);
            mc = up ? (mc + 1) % 4096 : (mc + 4095) % 4096;
            tick();
            chk("R10 chain count", {c2, c1, c0}, mc);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule